// File: doc/BRIEF.md
# Round-Robin Conversion Sequencer

This block decides when an analog-to-digital converter front end begins a conversion and which of its input channels it samples. Software-facing fields arrive through a single write strobe that carries all control fields at once: an enable, a one-shot launch trigger, a continuous-run bit, a channel number and a per-channel round-robin mask. On the converter side the block issues a one-cycle start pulse together with the channel number, then waits for a done strobe that carries a 12-bit result and an error flag.

When a conversion completes, the result is held in a register and two error indications are updated. The first reflects only the latest conversion. The second is sticky and stays set until software writes a clear. If the mask has any bit set, the channel number then steps to the next enabled channel, so a run of conversions sweeps the selected inputs in turn. In continuous mode launches are paced by an external tick, and a tick that arrives while a conversion is in flight is dropped.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, st_enable, st_cont, st_ready, st_err, st_err_sticky, conv_start, st_chan, st_mask and st_result are all 0.
- R2: st_ready is 1 exactly when the block is enabled and no conversion is in flight. It rises in the cycle after an enabling write and again in the cycle after a done strobe.
- R3: A write with cfg_single=1 and cfg_enable=1 while the block is ready gives exactly one conv_start pulse, one cycle long, in the cycle after the write. conv_chan then equals the cfg_chan of that write. The same write while a conversion is in flight launches nothing.
- R4: With enable at 0, neither a single-start write nor a pace tick launches a conversion.
- R5: While st_cont=1 and the block is ready, each pace_tick launches one conversion in the following cycle. Ticks during a conversion are ignored, and once st_cont is written to 0 no further launches occur.
- R6: st_result takes conv_data in the cycle after an accepted conv_done and holds it otherwise.
- R7: st_err takes conv_err of the latest conversion. st_err_sticky is set by any conversion with conv_err=1 and stays set through later error-free conversions.
- R8: A write with cfg_clr_sticky=1 clears st_err_sticky, and a write with it at 0 leaves it unchanged. An error completing in the same cycle as the clear leaves the flag set.
- R9: After an accepted conv_done with a nonzero st_mask (bit i enables channel i), st_chan moves to the lowest enabled channel above the current one. If there is none, it wraps to the lowest enabled channel. With a zero mask st_chan is unchanged. A write in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for all control fields |
| cfg_enable | input | 1 | Enable value to write |
| cfg_single | input | 1 | One-shot launch trigger (not stored) |
| cfg_cont | input | 1 | Continuous-run value to write |
| cfg_chan | input | 3 | Channel number to write |
| cfg_mask | input | 5 | Round-robin mask to write |
| cfg_clr_sticky | input | 1 | 1 clears the sticky error flag |
| pace_tick | input | 1 | Pacing tick for continuous mode |
| conv_done | input | 1 | Converter finished strobe |
| conv_data | input | 12 | Converter result |
| conv_err | input | 1 | Converter error flag |
| conv_start | output | 1 | One-cycle start pulse to converter |
| conv_chan | output | 3 | Channel for the conversion in flight |
| st_enable | output | 1 | Stored enable |
| st_cont | output | 1 | Stored continuous-run bit |
| st_chan | output | 3 | Current channel number |
| st_mask | output | 5 | Stored round-robin mask |
| st_ready | output | 1 | Ready for a new conversion |
| st_err | output | 1 | Error of latest conversion |
| st_err_sticky | output | 1 | Accumulated error flag |
| st_result | output | 12 | Latest conversion result |

## Verification
Every output is a register, so each result is due exactly one clock after its cause. conv_start and conv_chan appear one cycle after the write or tick. st_result, st_err, st_err_sticky, st_ready and the advanced st_chan appear one cycle after the done strobe. The bench changes inputs on the falling edge and reads outputs on the next falling edge, which is half a cycle after the register update. The absence of a launch is checked with a pulse counter read a few cycles after the stimulus.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned DEF_NUM_CH = 5;
  localparam int unsigned DEF_CH_W   = 3;
  localparam int unsigned DEF_RES_W  = 12;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } conv_state_e;
endpackage

// File: rtl/seq_rr_next.sv
module seq_rr_next #(
  parameter int unsigned NUM_CH = seq_pkg::DEF_NUM_CH,
  parameter int unsigned CH_W   = seq_pkg::DEF_CH_W
) (
  input  logic [CH_W-1:0]   cur,
  input  logic [NUM_CH-1:0] mask,
  output logic [CH_W-1:0]   nxt
);
  logic [CH_W-1:0] hi_pick;
  logic [CH_W-1:0] lo_pick;
  logic            hi_found;

  // Scan from the top down so the last hit is the lowest index.
  always_comb begin
    hi_pick  = '0;
    lo_pick  = '0;
    hi_found = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        lo_pick = CH_W'(i);
        if (i > int'(cur)) begin
          hi_pick  = CH_W'(i);
          hi_found = 1'b1;
        end
      end
    end
    if (mask == '0)    nxt = cur;
    else if (hi_found) nxt = hi_pick;
    else               nxt = lo_pick;
  end
endmodule

// File: rtl/seq_result.sv
module seq_result #(
  parameter int unsigned RES_W = seq_pkg::DEF_RES_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_ok,
  input  logic [RES_W-1:0] data,
  input  logic             err,
  input  logic             clr_sticky,
  output logic [RES_W-1:0] result_q,
  output logic             err_q,
  output logic             sticky_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      err_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      if (done_ok) begin
        result_q <= data;
        err_q    <= err;
      end
      // A new error wins over a clear in the same cycle.
      if (done_ok && err)  sticky_q <= 1'b1;
      else if (clr_sticky) sticky_q <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl #(
  parameter int unsigned NUM_CH = seq_pkg::DEF_NUM_CH,
  parameter int unsigned CH_W   = seq_pkg::DEF_CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_enable,
  input  logic              cfg_single,
  input  logic              cfg_cont,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [NUM_CH-1:0] cfg_mask,
  input  logic              pace_tick,
  input  logic              conv_done,
  input  logic [CH_W-1:0]   adv_chan,
  output logic              done_ok,
  output logic              en_q,
  output logic              cont_q,
  output logic [NUM_CH-1:0] mask_q,
  output logic [CH_W-1:0]   chan_q,
  output logic              ready_q,
  output logic              start_q,
  output logic [CH_W-1:0]   conv_chan_q
);
  import seq_pkg::*;

  conv_state_e       state_q, state_n;
  logic              en_n, cont_n, launch;
  logic [NUM_CH-1:0] mask_n;
  logic [CH_W-1:0]   chan_n;

  always_comb begin
    en_n    = cfg_wr ? cfg_enable : en_q;
    cont_n  = cfg_wr ? cfg_cont   : cont_q;
    mask_n  = cfg_wr ? cfg_mask   : mask_q;
    done_ok = conv_done && (state_q == ST_BUSY);
    if (cfg_wr)       chan_n = cfg_chan;
    else if (done_ok) chan_n = adv_chan;
    else              chan_n = chan_q;
    launch  = (state_q == ST_IDLE) && en_n &&
              ((cfg_wr && cfg_single) || (cont_n && pace_tick));
    if (launch)       state_n = ST_BUSY;
    else if (done_ok) state_n = ST_IDLE;
    else              state_n = state_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      en_q        <= 1'b0;
      cont_q      <= 1'b0;
      mask_q      <= '0;
      chan_q      <= '0;
      ready_q     <= 1'b0;
      start_q     <= 1'b0;
      conv_chan_q <= '0;
    end else begin
      state_q <= state_n;
      en_q    <= en_n;
      cont_q  <= cont_n;
      mask_q  <= mask_n;
      chan_q  <= chan_n;
      ready_q <= en_n && (state_n == ST_IDLE);
      start_q <= launch;
      if (launch) conv_chan_q <= chan_n;
    end
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int unsigned NUM_CH = seq_pkg::DEF_NUM_CH,
  parameter int unsigned CH_W   = seq_pkg::DEF_CH_W,
  parameter int unsigned RES_W  = seq_pkg::DEF_RES_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_enable,
  input  logic              cfg_single,
  input  logic              cfg_cont,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [NUM_CH-1:0] cfg_mask,
  input  logic              cfg_clr_sticky,
  input  logic              pace_tick,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              conv_err,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic              st_enable,
  output logic              st_cont,
  output logic [CH_W-1:0]   st_chan,
  output logic [NUM_CH-1:0] st_mask,
  output logic              st_ready,
  output logic              st_err,
  output logic              st_err_sticky,
  output logic [RES_W-1:0]  st_result
);
  logic [CH_W-1:0] adv_chan;
  logic            done_ok;

  seq_rr_next #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_rr (
    .cur  (st_chan),
    .mask (st_mask),
    .nxt  (adv_chan)
  );

  seq_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr      (cfg_wr),
    .cfg_enable  (cfg_enable),
    .cfg_single  (cfg_single),
    .cfg_cont    (cfg_cont),
    .cfg_chan    (cfg_chan),
    .cfg_mask    (cfg_mask),
    .pace_tick   (pace_tick),
    .conv_done   (conv_done),
    .adv_chan    (adv_chan),
    .done_ok     (done_ok),
    .en_q        (st_enable),
    .cont_q      (st_cont),
    .mask_q      (st_mask),
    .chan_q      (st_chan),
    .ready_q     (st_ready),
    .start_q     (conv_start),
    .conv_chan_q (conv_chan)
  );

  seq_result #(.RES_W(RES_W)) i_res (
    .clk        (clk),
    .rst        (rst),
    .done_ok    (done_ok),
    .data       (conv_data),
    .err        (conv_err),
    .clr_sticky (cfg_wr && cfg_clr_sticky),
    .result_q   (st_result),
    .err_q      (st_err),
    .sticky_q   (st_err_sticky)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int unsigned NUM_CH = seq_pkg::DEF_NUM_CH,
  parameter int unsigned CH_W   = seq_pkg::DEF_CH_W,
  parameter int unsigned RES_W  = seq_pkg::DEF_RES_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic              conv_done,
  input logic              conv_start,
  input logic              st_enable,
  input logic              st_ready,
  input logic              st_err,
  input logic              st_err_sticky,
  input logic [CH_W-1:0]   st_chan,
  input logic [NUM_CH-1:0] st_mask,
  input logic [RES_W-1:0]  st_result
);
  p_ready_not_starting_r2: assert property (@(posedge clk) disable iff (rst)
    st_ready |-> !conv_start);

  p_start_single_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  p_start_needs_enable_r4: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> st_enable);

  p_result_holds_r6: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> $stable(st_result));

  p_err_marks_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(st_err) |-> st_err_sticky);

  p_zero_mask_holds_chan_r9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_wr && st_mask == '0) |=> $stable(st_chan));
endmodule

bind conv_sequencer seq_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RES_W(RES_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_wr        (cfg_wr),
  .conv_done     (conv_done),
  .conv_start    (conv_start),
  .st_enable     (st_enable),
  .st_ready      (st_ready),
  .st_err        (st_err),
  .st_err_sticky (st_err_sticky),
  .st_chan       (st_chan),
  .st_mask       (st_mask),
  .st_result     (st_result)
);

// File: tb/test_conv_sequencer.sv
module test_conv_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 0, cfg_enable = 0, cfg_single = 0, cfg_cont = 0, cfg_clr_sticky = 0;
  logic [2:0]  cfg_chan = '0;
  logic [4:0]  cfg_mask = '0;
  logic        pace_tick = 0, conv_done = 0, conv_err = 0;
  logic [11:0] conv_data = '0;
  logic        conv_start, st_enable, st_cont, st_ready, st_err, st_err_sticky;
  logic [2:0]  conv_chan, st_chan;
  logic [4:0]  st_mask;
  logic [11:0] st_result;

  int n_chk = 0, n_fail = 0, n_start = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_sequencer i_conv_sequencer (.*);

  always @(posedge clk) if (!rst && conv_start) n_start++;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(bit en, bit single, bit cont, int chan, int mask, bit clr);
    cfg_enable = en; cfg_single = single; cfg_cont = cont;
    cfg_chan = 3'(chan); cfg_mask = 5'(mask); cfg_clr_sticky = clr; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0; cfg_single = 0; cfg_clr_sticky = 0;
  endtask

  task automatic done(int data, bit err);
    conv_data = 12'(data); conv_err = err; conv_done = 1;
    @(negedge clk);
    conv_done = 0; conv_err = 0;
  endtask

  task automatic tick();
    pace_tick = 1;
    @(negedge clk);
    pace_tick = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ready", st_ready, 0);
    chk("R1 start", conv_start, 0);
    chk("R1 chan", st_chan, 0);
    chk("R1 result", st_result, 0);
    chk("R1 sticky", st_err_sticky, 0);
    chk("R1 enable", st_enable, 0);
  endtask

  task automatic t_disabled();
    int s0 = n_start;
    wr(0, 1, 0, 0, 0, 0);
    chk("R4 single disabled start", conv_start, 0);
    chk("R2 ready disabled", st_ready, 0);
    wr(0, 0, 1, 0, 0, 0);
    tick();
    idle(2);
    chk("R4 tick disabled count", n_start, s0);
  endtask

  task automatic t_single();
    int s0;
    wr(1, 0, 0, 0, 0, 0);
    chk("R2 ready after enable", st_ready, 1);
    s0 = n_start;
    wr(1, 1, 0, 2, 0, 0);
    chk("R3 start pulse", conv_start, 1);
    chk("R3 chan", conv_chan, 2);
    chk("R2 ready busy", st_ready, 0);
    idle(1);
    chk("R3 pulse ends", conv_start, 0);
    wr(1, 1, 0, 2, 0, 0);
    chk("R3 busy single ignored", conv_start, 0);
    idle(2);
    chk("R3 one launch", n_start, s0 + 1);
    done(12'hABC, 0);
    chk("R6 result", st_result, 12'hABC);
    chk("R7 err clear", st_err, 0);
    chk("R2 ready after done", st_ready, 1);
    chk("R9 zero mask chan", st_chan, 2);
  endtask

  task automatic t_rr();
    wr(1, 1, 0, 1, 5'b10110, 0);
    chk("R3 rr chan1", conv_chan, 1);
    idle(1);
    done(5, 0);
    chk("R9 1->2", st_chan, 2);
    wr(1, 1, 0, 2, 5'b10110, 0);
    chk("R3 rr chan2", conv_chan, 2);
    done(6, 0);
    chk("R9 2->4", st_chan, 4);
    wr(1, 1, 0, 4, 5'b10110, 0);
    done(7, 0);
    chk("R9 wrap 4->1", st_chan, 1);
    chk("R6 result rr", st_result, 7);
  endtask

  task automatic t_cont();
    int s0;
    wr(1, 0, 1, 3, 0, 0);
    s0 = n_start;
    idle(3);
    chk("R5 no tick no start", n_start, s0);
    tick();
    chk("R5 tick start", conv_start, 1);
    chk("R5 tick chan", conv_chan, 3);
    tick();
    chk("R5 busy tick ignored", conv_start, 0);
    idle(1);
    chk("R5 count one", n_start, s0 + 1);
    done(100, 0);
    tick();
    chk("R5 second tick start", conv_start, 1);
    idle(1);
    done(101, 0);
    wr(1, 0, 0, 3, 0, 0);
    tick();
    idle(2);
    chk("R5 stopped", n_start, s0 + 2);
    chk("R2 ready stopped", st_ready, 1);
  endtask

  task automatic t_err();
    wr(1, 1, 0, 0, 0, 0);
    done(12'h123, 1);
    chk("R7 err set", st_err, 1);
    chk("R7 sticky set", st_err_sticky, 1);
    chk("R6 result err", st_result, 12'h123);
    wr(1, 1, 0, 0, 0, 0);
    done(12'h045, 0);
    chk("R7 err follows", st_err, 0);
    chk("R7 sticky holds", st_err_sticky, 1);
    wr(1, 0, 0, 0, 0, 0);
    chk("R8 no clear", st_err_sticky, 1);
    wr(1, 0, 0, 0, 0, 1);
    chk("R8 clear", st_err_sticky, 0);
    wr(1, 1, 0, 0, 0, 0);
    conv_data = 12'h077; conv_err = 1; conv_done = 1;
    wr(1, 0, 0, 0, 0, 1);
    conv_done = 0; conv_err = 0;
    chk("R8 set wins", st_err_sticky, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    t_reset();
    t_disabled();
    t_single();
    t_rr();
    t_cont();
    t_err();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule